// File: doc/BRIEF.md
# Flash Busy Status Poller

This block watches the data bus of a parallel NOR flash while the flash runs an internal program or erase. It issues read strobes to one fixed status location and decides from each returned byte whether the operation has finished. It has two detection modes. In toggle mode the flash flips bit 6 on every read while it is busy, so the block looks for two successive reads that agree on bit 6. In data-polling mode the flash returns the complement of the written bit 7 until it is done, so the block looks for bit 7 to match the expected data.

A controller pulses `start_i` with the mode, the expected byte and a wait count. The block then runs reads until it sees completion or reaches a hard loop limit. It pulses `done_o` when it stops. Along with that pulse it leaves two flags: a timeout flag, and a warning flag that marks a run which needed more polls than a soft threshold. A wait count of zero gives back-to-back polling, which suits byte and page programming. A large wait count spaces reads apart, which suits erases, where some parts need milliseconds between toggle reads. Because the wait is a cycle count loaded at start, the same logic works at any clock rate.

The read port is a request/response pair. `rd_valid_o` stays high until the bus side accepts it with `rd_ready_i`, so the bus may stall the poller for any number of cycles. Exactly one read is outstanding at a time. The response comes back on `rsp_valid_i`/`rsp_data_i`. The block is always ready for the response while it waits, and it ignores responses at any other time. The address of the status location is decoded outside the block.

Top module: `flash_busy_poller`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rd_valid_o`, `timeout_o` and `warn_o` are all 0.
- R2: A `start_i` pulse is accepted only while `busy_o` is 0. On acceptance it latches the mode, the expected byte and the wait count, and `busy_o` rises on the next cycle. A `start_i` while busy is ignored and does not change the latched settings.
- R3: In toggle mode (`mode_i`=0) the first read is a reference sample that is not counted. Each later read is a counted poll. The run completes on the first poll whose bit 6 (mask 0x40) equals bit 6 of the previous read; otherwise that poll becomes the new reference.
- R4: In data-polling mode (`mode_i`=1) every read is a counted poll. The run completes on the first poll whose bit 7 (mask 0x80) equals bit 7 of `expect_i`.
- R5: The first read of a run is requested on the cycle after the start is accepted. Between a response and the next request there are exactly `wait_i` idle cycles, with `rd_valid_o` low.
- R6: `rd_valid_o`, once high, stays high until a cycle with `rd_ready_i` high. Only one read is outstanding. A response presented while no read has been accepted is ignored.
- R7: `done_o` is high for exactly one cycle: the cycle after the response that ends the run. `busy_o` is 0 in that same cycle.
- R8: If LOOP_LIMIT counted polls pass without completion, the run ends with `done_o` and `timeout_o`=1. A completion on the final allowed poll ends the run with `timeout_o`=0.
- R9: When a run ends, `warn_o` is 1 if the number of counted polls exceeds WARN_LIMIT, and 0 otherwise. A count exactly equal to WARN_LIMIT gives 0.
- R10: `timeout_o` and `warn_o` keep their values from the end of a run until the next accepted start, which clears both on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a polling run (taken only when idle) |
| mode_i | input | 1 | 0 = toggle-bit detection, 1 = data-bit detection |
| expect_i | input | 8 | Byte that was written; bit 7 used in data mode |
| wait_i | input | DLY_W | Idle cycles between a response and the next read |
| rd_valid_o | output | 1 | Read request to the status location |
| rd_ready_i | input | 1 | Bus accepts the read request |
| rsp_valid_i | input | 1 | Read data returned |
| rsp_data_i | input | 8 | Byte read from the flash |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| timeout_o | output | 1 | Last run hit the hard loop limit |
| warn_o | output | 1 | Last run needed more polls than WARN_LIMIT |

## Verification
The bench goes after the corners where a poller usually goes wrong.

- **Reference sample in toggle mode.** A design that counts the reference read, or compares it against nothing, finishes one poll early or reports the wrong warning.
- **Warning threshold.** Runs of exactly WARN_LIMIT and WARN_LIMIT+1 polls expose a threshold compare that uses `>=` in place of `>`.
- **Loop limit.** A run that matches on the last allowed poll catches a limit check made before the match.
- **Wait count.** The idle gap is measured cycle by cycle, which catches an off-by-one wait or a wait wrongly placed before the first read.
- **Handshake.** Stalling the request while a stray response is driven would make a design that drops `rd_valid_o` early, or takes an unrequested response, end the run.
- **Start while busy.** A restart carrying data-mode settings would make a design that relatches them finish on the wrong bit.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic {
    MODE_TOGGLE = 1'b0,
    MODE_DATA   = 1'b1
  } poll_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_RSP
  } poll_state_e;

  localparam int unsigned TOGGLE_BIT = 6;
  localparam int unsigned DATA_BIT   = 7;
endpackage

// File: rtl/poll_delay.sv
module poll_delay #(
  parameter int unsigned DLY_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DLY_W-1:0] val_i,
  output logic             expire_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  // last idle cycle of the wait window
  assign expire_o = (cnt_q == DLY_W'(1));
endmodule

// File: rtl/poll_iter.sv
module poll_iter #(
  parameter int unsigned LOOP_LIMIT = 32'h0FFF_FFFF,
  parameter int unsigned WARN_LIMIT = 32'h0010_0000,
  parameter int unsigned CNT_W      = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o,
  output logic over_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nx;

  // count this poll would reach if it is the one being judged now
  assign cnt_nx = {1'b0, cnt_q} + 1'b1;
  assign last_o = (cnt_nx >= (CNT_W+1)'(LOOP_LIMIT));
  assign over_o = (cnt_nx >  (CNT_W+1)'(WARN_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_nx[CNT_W-1:0];
  end
endmodule

// File: rtl/poll_match.sv
module poll_match
  import poll_pkg::*;
(
  input  poll_mode_e  mode_i,
  input  logic        ref_bit_i,
  input  logic        exp_bit_i,
  input  logic [7:0]  data_i,
  output logic        hit_o
);
  always_comb begin
    if (mode_i == MODE_TOGGLE) hit_o = (data_i[TOGGLE_BIT] == ref_bit_i);
    else                       hit_o = (data_i[DATA_BIT]   == exp_bit_i);
  end
endmodule

// File: rtl/flash_busy_poller.sv
module flash_busy_poller
  import poll_pkg::*;
#(
  parameter int unsigned LOOP_LIMIT = 32'h0FFF_FFFF,
  parameter int unsigned WARN_LIMIT = 32'h0010_0000,
  parameter int unsigned DLY_W      = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [7:0]       expect_i,
  input  logic [DLY_W-1:0] wait_i,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  input  logic             rsp_valid_i,
  input  logic [7:0]       rsp_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic             warn_o
);
  localparam int unsigned CNT_W = $clog2(LOOP_LIMIT + 1);

  poll_state_e      st_q;
  poll_mode_e       mode_q;
  logic             exp_q, ref_q, prime_q;
  logic [DLY_W-1:0] wait_q;
  logic             done_q, to_q, warn_q;

  logic rsp_take, poll_take, hit, last, over, finish, expire;

  assign rsp_take  = (st_q == ST_RSP) && rsp_valid_i;
  assign poll_take = rsp_take && !prime_q;
  assign finish    = poll_take && (hit || last);

  poll_match u_match (
    .mode_i    (mode_q),
    .ref_bit_i (ref_q),
    .exp_bit_i (exp_q),
    .data_i    (rsp_data_i),
    .hit_o     (hit)
  );

  poll_iter #(
    .LOOP_LIMIT (LOOP_LIMIT),
    .WARN_LIMIT (WARN_LIMIT),
    .CNT_W      (CNT_W)
  ) u_iter (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  ((st_q == ST_IDLE) && start_i),
    .inc_i  (poll_take),
    .last_o (last),
    .over_o (over)
  );

  poll_delay #(.DLY_W(DLY_W)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (rsp_take && !finish && (wait_q != '0)),
    .val_i    (wait_q),
    .expire_o (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      mode_q  <= MODE_TOGGLE;
      exp_q   <= 1'b0;
      ref_q   <= 1'b0;
      prime_q <= 1'b0;
      wait_q  <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          mode_q  <= poll_mode_e'(mode_i);
          exp_q   <= expect_i[DATA_BIT];
          wait_q  <= wait_i;
          prime_q <= (poll_mode_e'(mode_i) == MODE_TOGGLE);
          to_q    <= 1'b0;
          warn_q  <= 1'b0;
          st_q    <= ST_REQ;
        end
        ST_WAIT: if (expire)     st_q <= ST_REQ;
        ST_REQ:  if (rd_ready_i) st_q <= ST_RSP;
        ST_RSP: if (rsp_valid_i) begin
          if (finish) begin
            done_q <= 1'b1;
            to_q   <= !hit;
            warn_q <= over;
            st_q   <= ST_IDLE;
          end else begin
            ref_q   <= rsp_data_i[TOGGLE_BIT];
            prime_q <= 1'b0;
            st_q    <= (wait_q == '0) ? ST_REQ : ST_WAIT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid_o = (st_q == ST_REQ);
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign timeout_o  = to_q;
  assign warn_o     = warn_q;
endmodule

// File: rtl/poll_chk.sv
module poll_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_valid_o,
  input logic rd_ready_i,
  input logic busy_o,
  input logic done_o,
  input logic timeout_o,
  input logic warn_o
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> rd_valid_o);
  // R6
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> busy_o);
  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  // R8
  to_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> done_o);
  // R9
  warn_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_o) |-> done_o);
endmodule

bind flash_busy_poller poll_chk i_poll_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_valid_o (rd_valid_o),
  .rd_ready_i (rd_ready_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .timeout_o  (timeout_o),
  .warn_o     (warn_o)
);

// File: tb/test_flash_busy_poller.sv
module test_flash_busy_poller;
  localparam int LIM = 12;
  localparam int WRN = 4;
  localparam int DW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, mode_i = 1'b0;
  logic [7:0]    expect_i = '0;
  logic [DW-1:0] wait_i = '0;
  logic          rd_ready_i = 1'b0, rsp_valid_i = 1'b0;
  logic [7:0]    rsp_data_i = '0;
  logic          rd_valid_o, busy_o, done_o, timeout_o, warn_o;
  int            total = 0, bad = 0;
  bit            finished = 0;

  always #10 clk = ~clk;

  flash_busy_poller #(.LOOP_LIMIT(LIM), .WARN_LIMIT(WRN), .DLY_W(DW)) i_flash_busy_poller (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .expect_i(expect_i),
    .wait_i(wait_i), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
    .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i), .busy_o(busy_o),
    .done_o(done_o), .timeout_o(timeout_o), .warn_o(warn_o));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic begin_run(logic m, logic [7:0] e, logic [DW-1:0] w);
    start_i = 1'b1; mode_i = m; expect_i = e; wait_i = w;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0; mode_i = ~m; expect_i = ~e; wait_i = '0;
  endtask

  // serve one read: returns idle gap; optional stall with stray response
  task automatic serve(logic [7:0] d, int hold, output int gap);
    gap = 0;
    while (!rd_valid_o) begin gap++; @(posedge clk); @(negedge clk); end
    for (int h = 0; h < hold; h++) begin
      rsp_valid_i = 1'b1; rsp_data_i = d ^ 8'hC0;
      @(posedge clk); @(negedge clk);
      chk("R6 request held", rd_valid_o, 1);
      chk("R6 stray response", done_o, 0);
    end
    rsp_valid_i = 1'b0;
    rd_ready_i = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_ready_i = 1'b0;
    rsp_valid_i = 1'b1; rsp_data_i = d;
    @(posedge clk); @(negedge clk);
    rsp_valid_i = 1'b0;
  endtask

  // toggle run finishing on poll n (n > LIM means never match -> timeout)
  task automatic t_toggle(int n, int w, int exp_warn);
    int g;
    int stop;
    logic v;
    stop = (n > LIM) ? LIM : n;
    begin_run(1'b0, 8'h00, DW'(w));
    chk("R2 busy after start", busy_o, 1);
    serve(8'h15, 0, g);
    chk("R5 first read immediate", g, 0);
    chk("R3 reference read uncounted", done_o, 0);
    for (int k = 1; k <= stop; k++) begin
      v = (k < n) ? k[0] : 1'(k - 1);
      serve({1'b0, v, 6'h2A}, 0, g);
      chk("R5 inter-read gap", g, w);
      if (k < stop) chk("R3 still polling", done_o, 0);
    end
    chk("R7 done pulse", done_o, 1);
    chk("R7 idle at done", busy_o, 0);
    chk("R8 timeout flag", timeout_o, (n > LIM) ? 1 : 0);
    chk("R9 warn flag", warn_o, exp_warn);
    @(posedge clk); @(negedge clk);
    chk("R7 done one cycle", done_o, 0);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 rd_valid", rd_valid_o, 0);
    chk("R1 timeout", timeout_o, 0);
    chk("R1 warn", warn_o, 0);
  endtask

  task automatic t_data;
    int g;
    begin_run(1'b1, 8'h80, '0);
    serve(8'h00, 0, g); chk("R4 no match", done_o, 0);
    serve(8'h7F, 0, g); chk("R4 no match", done_o, 0);
    serve(8'hC3, 0, g); chk("R4 match bit7", done_o, 1);
    chk("R4 no timeout", timeout_o, 0);
    begin_run(1'b1, 8'h00, '0);
    serve(8'h7F, 0, g); chk("R4 first poll match", done_o, 1);
    chk("R9 one poll no warn", warn_o, 0);
  endtask

  task automatic t_ignore;
    int g;
    begin_run(1'b0, 8'h00, '0);
    serve(8'h00, 0, g);
    start_i = 1'b1; mode_i = 1'b1; expect_i = 8'h80; wait_i = 5;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    serve(8'hC0, 0, g);
    chk("R2 restart ignored, mode kept", done_o, 0);
    chk("R2 restart ignored, wait kept", g, 0);
    serve(8'hC0, 0, g);
    chk("R2 toggle completion", done_o, 1);
  endtask

  task automatic t_backpressure;
    int g;
    begin_run(1'b0, 8'h00, '0);
    serve(8'h40, 3, g);
    serve(8'h00, 2, g);
    chk("R6 no early end", done_o, 0);
    serve(8'h00, 0, g);
    chk("R6 completes after stalls", done_o, 1);
  endtask

  task automatic t_flags;
    int g;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 timeout held", timeout_o, 1);
    chk("R10 warn held", warn_o, 1);
    begin_run(1'b1, 8'h80, '0);
    chk("R10 timeout cleared", timeout_o, 0);
    chk("R10 warn cleared", warn_o, 0);
    serve(8'h80, 0, g);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    t_toggle(1, 0, 0);
    t_toggle(WRN, 0, 0);
    t_toggle(WRN + 1, 0, 1);
    t_toggle(3, 3, 0);
    t_data();
    t_ignore();
    t_backpressure();
    t_toggle(LIM, 0, 1);
    t_toggle(LIM + 1, 1, 1);
    t_flags();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule